// File: doc/BRIEF.md
# Banked Internal Data Memory Controller

This block resolves every access an 8-bit accumulator core makes into its 256-byte internal data space. The lower half is 128 bytes of RAM held inside the block. The upper half belongs to special registers that live elsewhere on the chip. The block reaches those registers through a small combinational side bus and keeps none of their contents.

The core picks the kind of access by raising one of six strobes:

- a direct byte address;
- an indirect byte access through working register 0 or 1 of the active bank;
- a working-register index 0 to 7 in the active bank;
- a single-bit address;
- a push;
- a pop.

The active bank comes from bits 4 and 3 of the status byte, which is supplied on an input. Bit addresses in the lower half land in a 16-byte window of RAM. Bit addresses in the upper half land in special registers whose address is a multiple of eight. The stack pointer is kept inside the block.

Read data is combinational in the cycle of the strobe. Writes, including bit writes, take effect at the next rising clock edge. A bit write is a read-modify-write of the containing byte, done in one cycle.

Top module: `dmem_space`

## Requirements
- R1: After reset the stack pointer reads 07h and every low RAM byte (00h to 7Fh) reads 00h.
- R2: A register access with index n (0 to 7) reaches RAM byte 8*b + n, where b = status[4:3]. The other status bits have no effect.
- R3: A direct access with addr below 80h reads and writes the RAM byte at addr. A direct access with addr at 80h or above raises xreg_sel and xreg_addr = addr. It returns xreg_rdata on rdata, and on a write raises xreg_we with xreg_wdata = wdata. RAM is left untouched.
- R4: An indirect access uses as its address the RAM byte at 8*b + ri_sel. A pointer below 80h reaches that RAM byte. A pointer at 80h or above has no effect: rdata is 00h and xreg_sel stays low.
- R5: A bit address k below 80h reaches bit (k mod 8) of RAM byte 20h + (k div 8), which is reported on rbit. A bit write changes only that bit.
- R6: A bit address k at 80h or above raises xreg_sel with xreg_addr = k with its low three bits cleared. rbit = xreg_rdata[k mod 8]. A write raises xreg_we, and xreg_wdata is xreg_rdata with only bit (k mod 8) set to wbit.
- R7: A push adds one to the stack pointer and writes wdata at the new pointer value.
- R8: A pop shows the byte at the current stack pointer on rdata in the same cycle, then subtracts one from the pointer.
- R9: The stack pointer wraps modulo 256. A push whose new pointer is 80h or above writes nothing. A pop at a pointer of 80h or above returns 00h.
- R10: At most one strobe is raised per cycle. With none raised, rdata and rbit are 0, xreg_sel is low, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| status | input | 8 | Status byte; bits 4:3 pick the register bank |
| dir_en | input | 1 | Direct byte access strobe |
| ind_en | input | 1 | Indirect byte access strobe |
| reg_en | input | 1 | Working-register access strobe |
| bit_en | input | 1 | Single-bit access strobe |
| push_en | input | 1 | Stack push strobe |
| pop_en | input | 1 | Stack pop strobe |
| wr_en | input | 1 | Write qualifier for direct, indirect, register and bit access |
| addr | input | 8 | Direct byte address or bit address |
| ri_sel | input | 1 | Pointer register choice for indirect access (0 or 1) |
| reg_idx | input | 3 | Working-register index |
| wdata | input | 8 | Byte write data, also push data |
| wbit | input | 1 | Bit write value |
| rdata | output | 8 | Byte read data, also pop data |
| rbit | output | 1 | Bit read data |
| sp | output | 8 | Current stack pointer |
| xreg_sel | output | 1 | Special-register access active |
| xreg_we | output | 1 | Special-register write |
| xreg_addr | output | 8 | Special-register byte address |
| xreg_wdata | output | 8 | Special-register write byte |
| xreg_rdata | input | 8 | Special-register read byte from the register file |

## Verification
The assertions assume that no two strobes rise in the same cycle. They also assume that status and xreg_rdata hold steady around each rising edge, because the bit-write merge reads the byte combinationally. The bench drives all inputs at the falling edge and raises exactly one strobe per operation. It changes status and xreg_rdata only between operations. The bench model tracks every RAM byte and the stack pointer, so the pointer walks through its wrap point with known contents under it.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int BANK_W    = 2;
  localparam int IDX_W     = 3;
  localparam int POS_W     = $clog2(DATA_W);
  localparam int LOW_AW    = ADDR_W - 1;
  localparam int LOW_DEPTH = 2 ** LOW_AW;

  localparam logic [ADDR_W-1:0] BIT_WIN_BASE = 8'h20;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_RAM  = 2'd1,
    TGT_XREG = 2'd2
  } tgt_e;

  // upper half of the space is the special-register region
  function automatic logic is_upper(addr_t a);
    return a[ADDR_W-1];
  endfunction

  // byte address of working register idx in bank
  function automatic addr_t reg_home(logic [BANK_W-1:0] bank,
                                     logic [IDX_W-1:0]  idx);
    return addr_t'({bank, idx});
  endfunction

  // byte that holds a given bit address
  function automatic addr_t bit_home(addr_t baddr);
    if (baddr[ADDR_W-1])
      return {baddr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
    return BIT_WIN_BASE + addr_t'(baddr[ADDR_W-2:POS_W]);
  endfunction

  function automatic byte_t bit_mask(logic [POS_W-1:0] pos);
    return byte_t'(1) << pos;
  endfunction

  // replace one bit of a byte, keep the rest
  function automatic byte_t bit_put(byte_t b, logic [POS_W-1:0] pos, logic v);
    return v ? (b | bit_mask(pos)) : (b & ~bit_mask(pos));
  endfunction

endpackage

// File: rtl/dmem_stack.sv
module dmem_stack
  import dmem_pkg::*;
#(
  parameter addr_t SP_RESET = 8'h07
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_en,
  input  logic  pop_en,
  output addr_t sp,
  output addr_t sp_inc
);

  assign sp_inc = sp + addr_t'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= SP_RESET;
    else if (push_en) sp <= sp_inc;
    else if (pop_en)  sp <= sp - addr_t'(1);
  end

  // R1
  sp_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sp == SP_RESET);

  // R7
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> sp == $past(sp) + 8'd1);

  // R8
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> sp == $past(sp) - 8'd1);

  // R10
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_en && !pop_en) |=> $stable(sp));

endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  addr_t             acc_addr,
  output byte_t             acc_rdata,
  input  logic [LOW_AW-1:0] ptr_addr,
  output byte_t             ptr_rdata,
  input  logic              we,
  input  logic              bit_mode,
  input  logic [POS_W-1:0]  pos,
  input  byte_t             wbyte,
  input  logic              wbit
);

  byte_t mem [LOW_DEPTH];
  byte_t next_byte;
  byte_t keep_mask;

  assign acc_rdata = mem[acc_addr[LOW_AW-1:0]];
  assign ptr_rdata = mem[ptr_addr];
  assign keep_mask = ~bit_mask(pos);

  // bit writes merge into the byte read in the same cycle
  assign next_byte = bit_mode ? bit_put(acc_rdata, pos, wbit) : wbyte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LOW_DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[acc_addr[LOW_AW-1:0]] <= next_byte;
    end
  end

  // R3
  ram_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !acc_addr[ADDR_W-1]);

  // R5
  bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bit_mode) |=>
      ((mem[$past(acc_addr[LOW_AW-1:0])] & $past(keep_mask)) ==
       ($past(acc_rdata) & $past(keep_mask))));

endmodule

// File: rtl/dmem_resolve.sv
module dmem_resolve
  import dmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_en,
  input  logic              ind_en,
  input  logic              reg_en,
  input  logic              bit_en,
  input  logic              push_en,
  input  logic              pop_en,
  input  logic              we,
  input  addr_t             addr_in,
  input  logic              ri_sel,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BANK_W-1:0] bank,
  input  byte_t             ptr_data,
  input  addr_t             sp,
  input  addr_t             sp_inc,
  output logic [LOW_AW-1:0] ptr_addr,
  output tgt_e              tgt,
  output addr_t             res_addr,
  output logic              bit_acc,
  output logic [POS_W-1:0]  pos,
  output logic              res_wr
);

  // pointer register of the active bank
  assign ptr_addr = LOW_AW'({bank, {(IDX_W-1){1'b0}}, ri_sel});

  always_comb begin
    tgt      = TGT_NONE;
    res_addr = '0;
    bit_acc  = 1'b0;
    pos      = '0;
    res_wr   = 1'b0;
    if (dir_en) begin
      res_addr = addr_in;
      tgt      = is_upper(addr_in) ? TGT_XREG : TGT_RAM;
      res_wr   = we;
    end else if (ind_en) begin
      res_addr = ptr_data;
      tgt      = is_upper(ptr_data) ? TGT_NONE : TGT_RAM;
      res_wr   = we;
    end else if (reg_en) begin
      res_addr = reg_home(bank, reg_idx);
      tgt      = TGT_RAM;
      res_wr   = we;
    end else if (bit_en) begin
      res_addr = bit_home(addr_in);
      tgt      = is_upper(addr_in) ? TGT_XREG : TGT_RAM;
      bit_acc  = 1'b1;
      pos      = addr_in[POS_W-1:0];
      res_wr   = we;
    end else if (push_en) begin
      res_addr = sp_inc;
      tgt      = is_upper(sp_inc) ? TGT_NONE : TGT_RAM;
      res_wr   = 1'b1;
    end else if (pop_en) begin
      res_addr = sp;
      tgt      = is_upper(sp) ? TGT_NONE : TGT_RAM;
    end
  end

  // R2
  reg_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en |-> (res_addr[7:5] == 3'b000 && res_addr[4:3] == bank));

  // R5
  bit_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !addr_in[7]) |-> (res_addr >= 8'h20 && res_addr <= 8'h2F));

endmodule

// File: rtl/dmem_space.sv
module dmem_space
  import dmem_pkg::*;
#(
  parameter logic [7:0] SP_RESET = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] status,
  input  logic       dir_en,
  input  logic       ind_en,
  input  logic       reg_en,
  input  logic       bit_en,
  input  logic       push_en,
  input  logic       pop_en,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic       ri_sel,
  input  logic [2:0] reg_idx,
  input  logic [7:0] wdata,
  input  logic       wbit,
  output logic [7:0] rdata,
  output logic       rbit,
  output logic [7:0] sp,
  output logic       xreg_sel,
  output logic       xreg_we,
  output logic [7:0] xreg_addr,
  output logic [7:0] xreg_wdata,
  input  logic [7:0] xreg_rdata
);

  logic [BANK_W-1:0] bank;
  logic              unused_status;
  addr_t             sp_inc;
  logic [LOW_AW-1:0] ptr_addr;
  byte_t             ptr_rd;
  byte_t             ram_rd;
  tgt_e              tgt;
  addr_t             res_addr;
  logic              bit_acc;
  logic [POS_W-1:0]  pos;
  logic              res_wr;
  logic              ram_we;

  assign bank          = status[4:3];
  assign unused_status = ^{status[7:5], status[2:0]};

  dmem_stack #(.SP_RESET(SP_RESET)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_en (push_en),
    .pop_en  (pop_en),
    .sp      (sp),
    .sp_inc  (sp_inc)
  );

  dmem_resolve u_resolve (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_en   (dir_en),
    .ind_en   (ind_en),
    .reg_en   (reg_en),
    .bit_en   (bit_en),
    .push_en  (push_en),
    .pop_en   (pop_en),
    .we       (wr_en),
    .addr_in  (addr),
    .ri_sel   (ri_sel),
    .reg_idx  (reg_idx),
    .bank     (bank),
    .ptr_data (ptr_rd),
    .sp       (sp),
    .sp_inc   (sp_inc),
    .ptr_addr (ptr_addr),
    .tgt      (tgt),
    .res_addr (res_addr),
    .bit_acc  (bit_acc),
    .pos      (pos),
    .res_wr   (res_wr)
  );

  assign ram_we = (tgt == TGT_RAM) && res_wr;

  dmem_ram u_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (res_addr),
    .acc_rdata (ram_rd),
    .ptr_addr  (ptr_addr),
    .ptr_rdata (ptr_rd),
    .we        (ram_we),
    .bit_mode  (bit_acc),
    .pos       (pos),
    .wbyte     (wdata),
    .wbit      (wbit)
  );

  always_comb begin
    case (tgt)
      TGT_RAM:  rdata = ram_rd;
      TGT_XREG: rdata = xreg_rdata;
      default:  rdata = '0;
    endcase
  end

  assign rbit       = bit_acc & rdata[pos];
  assign xreg_sel   = (tgt == TGT_XREG);
  assign xreg_we    = xreg_sel && res_wr;
  assign xreg_addr  = xreg_sel ? res_addr : '0;
  assign xreg_wdata = !xreg_we ? '0 :
                      bit_acc  ? bit_put(xreg_rdata, pos, wbit) : wdata;

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dir_en, ind_en, reg_en, bit_en, push_en, pop_en}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_en || ind_en || reg_en || bit_en || push_en || pop_en)
      |-> (!xreg_sel && rdata == 8'h00 && !ram_we));

  // R3
  dir_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_en && addr[7]) |-> (xreg_sel && !ram_we && xreg_addr == addr));

  // R4
  ind_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ind_en && ptr_rd[7]) |-> (!ram_we && !xreg_sel && rdata == 8'h00));

  // R9
  stk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_en && sp_inc[7]) || (pop_en && sp[7])) |-> (!ram_we && rdata == 8'h00));

endmodule

// File: tb/dmem_space_tb.sv
module dmem_space_tb;

  localparam int K_DIR  = 0;
  localparam int K_IND  = 1;
  localparam int K_REG  = 2;
  localparam int K_BIT  = 3;
  localparam int K_PUSH = 4;
  localparam int K_POP  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] status = 8'h00;
  logic       dir_en = 0, ind_en = 0, reg_en = 0, bit_en = 0, push_en = 0, pop_en = 0;
  logic       wr_en = 0;
  logic [7:0] addr = 8'h00;
  logic       ri_sel = 0;
  logic [2:0] reg_idx = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic       wbit = 0;
  logic [7:0] rdata;
  logic       rbit;
  logic [7:0] sp;
  logic       xreg_sel, xreg_we;
  logic [7:0] xreg_addr, xreg_wdata;
  logic [7:0] xreg_rdata = 8'h00;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m [128];
  logic [7:0] spm;
  logic [7:0] c_rdata, c_saddr, c_swd;
  logic       c_rbit, c_sel, c_swe;

  always #4 clk = ~clk;

  dmem_space u_dut (
    .clk(clk), .rst_n(rst_n), .status(status),
    .dir_en(dir_en), .ind_en(ind_en), .reg_en(reg_en), .bit_en(bit_en),
    .push_en(push_en), .pop_en(pop_en), .wr_en(wr_en), .addr(addr),
    .ri_sel(ri_sel), .reg_idx(reg_idx), .wdata(wdata), .wbit(wbit),
    .rdata(rdata), .rbit(rbit), .sp(sp),
    .xreg_sel(xreg_sel), .xreg_we(xreg_we), .xreg_addr(xreg_addr),
    .xreg_wdata(xreg_wdata), .xreg_rdata(xreg_rdata)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic issue(input int k, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic b, input logic rs,
                       input logic [2:0] ix);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; wbit = b; ri_sel = rs; reg_idx = ix;
    dir_en = (k == K_DIR); ind_en = (k == K_IND); reg_en = (k == K_REG);
    bit_en = (k == K_BIT); push_en = (k == K_PUSH); pop_en = (k == K_POP);
    #1;
    c_rdata = rdata; c_rbit = rbit; c_sel = xreg_sel; c_swe = xreg_we;
    c_saddr = xreg_addr; c_swd = xreg_wdata;
    @(posedge clk);
    #1;
    dir_en = 0; ind_en = 0; reg_en = 0; bit_en = 0; push_en = 0; pop_en = 0; wr_en = 0;
  endtask

  task automatic sweep_ram(input string req);
    for (int a = 0; a < 128; a++) begin
      issue(K_DIR, 0, 8'(a), 8'h00, 0, 0, 3'd0);
      chk(req, c_rdata, m[a]);
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    #1 chk("R1 sp", sp, 8'h07);
    spm = 8'h07;
    sweep_ram("R1 clear");

    // R10: idle cycles leave everything quiet
    xreg_rdata = 8'h6D;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R10 idle rdata", rdata, 8'h00);
      chk("R10 idle sel", {7'b0, xreg_sel}, 8'h00);
      chk("R10 idle sp", sp, spm);
    end

    // R3: direct RAM sweep
    for (int a = 0; a < 128; a++) begin
      issue(K_DIR, 1, 8'(a), 8'(a * 37 + 11), 0, 0, 3'd0);
      m[a] = 8'(a * 37 + 11);
      chk("R3 ram sel", {7'b0, c_sel}, 8'h00);
    end
    sweep_ram("R3 ram");

    // R2: every register of every bank, junk in other status bits
    for (int bk = 0; bk < 4; bk++) begin
      status = (8'hE7 & ~8'h18) | 8'(bk << 3);
      for (int ix = 0; ix < 8; ix++) begin
        issue(K_REG, 1, 8'h00, 8'((bk * 8 + ix) ^ 8'h5A), 0, 0, 3'(ix));
        m[bk * 8 + ix] = 8'((bk * 8 + ix) ^ 8'h5A);
      end
      for (int ix = 0; ix < 8; ix++) begin
        issue(K_REG, 0, 8'h00, 8'h00, 0, 0, 3'(ix));
        chk("R2 reg read", c_rdata, m[bk * 8 + ix]);
        issue(K_DIR, 0, 8'(bk * 8 + ix), 8'h00, 0, 0, 3'd0);
        chk("R2 reg home", c_rdata, m[bk * 8 + ix]);
      end
    end
    status = 8'h00;

    // R5: all 128 RAM bits, written then read back
    for (int b = 0; b < 128; b++) begin
      logic v;
      v = 1'((b * 7 + (b >> 2)) >> 1);
      issue(K_BIT, 1, 8'(b), 8'h00, v, 0, 3'd0);
      m[32 + (b >> 3)][b & 7] = v;
    end
    for (int b = 0; b < 128; b++) begin
      issue(K_BIT, 0, 8'(b), 8'h00, 0, 0, 3'd0);
      chk("R5 bit read", {7'b0, c_rbit}, {7'b0, m[32 + (b >> 3)][b & 7]});
    end
    sweep_ram("R5 window");

    // R6: upper bit addresses reach the special registers
    for (int b = 128; b < 256; b++) begin
      logic [7:0] p;
      p = 8'(b * 29 + 3);
      xreg_rdata = p;
      issue(K_BIT, 0, 8'(b), 8'h00, 0, 0, 3'd0);
      chk("R6 sel", {7'b0, c_sel}, 8'h01);
      chk("R6 addr", c_saddr, 8'(b) & 8'hF8);
      chk("R6 rbit", {7'b0, c_rbit}, {7'b0, p[b & 7]});
      issue(K_BIT, 1, 8'(b), 8'h00, ~p[b & 7], 0, 3'd0);
      chk("R6 we", {7'b0, c_swe}, 8'h01);
      chk("R6 merge", c_swd, p ^ 8'(1 << (b & 7)));
    end

    // R3: direct upper addresses go to the special-register bus
    for (int a = 128; a < 256; a++) begin
      xreg_rdata = ~8'(a);
      issue(K_DIR, 0, 8'(a), 8'h00, 0, 0, 3'd0);
      chk("R3 xreg addr", c_saddr, 8'(a));
      chk("R3 xreg rd", c_rdata, ~8'(a));
      chk("R3 xreg rd we", {7'b0, c_swe}, 8'h00);
      issue(K_DIR, 1, 8'(a), 8'(a) ^ 8'h3C, 0, 0, 3'd0);
      chk("R3 xreg we", {7'b0, c_swe}, 8'h01);
      chk("R3 xreg wd", c_swd, 8'(a) ^ 8'h3C);
    end
    sweep_ram("R3 untouched");

    // R4: indirect through both pointer registers of bank 2
    status = 8'h10;
    for (int p = 32; p < 128; p++) begin
      issue(K_REG, 1, 8'h00, 8'(p), 0, 0, 3'd0);
      m[16] = 8'(p);
      issue(K_IND, 0, 8'h00, 8'h00, 0, 0, 3'd0);
      chk("R4 ind read", c_rdata, m[p]);
      issue(K_IND, 1, 8'h00, 8'(p) ^ 8'hFF, 0, 0, 3'd0);
      m[p] = 8'(p) ^ 8'hFF;
    end
    issue(K_REG, 1, 8'h00, 8'h90, 0, 0, 3'd1);
    m[17] = 8'h90;
    xreg_rdata = 8'hC3;
    issue(K_IND, 0, 8'h00, 8'h00, 0, 1, 3'd0);
    chk("R4 high rdata", c_rdata, 8'h00);
    chk("R4 high sel", {7'b0, c_sel}, 8'h00);
    issue(K_IND, 1, 8'h00, 8'h77, 0, 1, 3'd0);
    chk("R4 high wsel", {7'b0, c_sel}, 8'h00);
    sweep_ram("R4 ram");
    status = 8'h00;

    // R7 / R8: push three, pop three
    for (int i = 1; i <= 3; i++) begin
      issue(K_PUSH, 0, 8'h00, 8'(i * 17), 0, 0, 3'd0);
      spm = spm + 8'd1;
      m[spm] = 8'(i * 17);
      chk("R7 push sp", sp, spm);
    end
    for (int i = 0; i < 3; i++) begin
      issue(K_POP, 0, 8'h00, 8'h00, 0, 0, 3'd0);
      chk("R8 pop data", c_rdata, m[spm]);
      spm = spm - 8'd1;
      chk("R8 pop sp", sp, spm);
    end

    // R9: pop past zero, then come back with pushes
    for (int i = 0; i < 8; i++) begin
      issue(K_POP, 0, 8'h00, 8'h00, 0, 0, 3'd0);
      chk("R8 pop data", c_rdata, m[spm]);
      spm = spm - 8'd1;
    end
    chk("R9 wrap sp", sp, 8'hFF);
    issue(K_POP, 0, 8'h00, 8'h00, 0, 0, 3'd0);
    chk("R9 high pop", c_rdata, 8'h00);
    chk("R9 sp FE", sp, 8'hFE);
    issue(K_PUSH, 0, 8'h00, 8'h99, 0, 0, 3'd0);
    chk("R9 sp FF", sp, 8'hFF);
    issue(K_PUSH, 0, 8'h00, 8'hAB, 0, 0, 3'd0);
    m[0] = 8'hAB;
    chk("R9 sp 00", sp, 8'h00);
    sweep_ram("R9 ram");

    finish_run();
  end

endmodule